// File: doc/BRIEF.md
# Debounced GPIO Port Interrupt Unit

This block watches an 8-bit group of input pins and turns selected transitions into an interrupt request. Each pin is brought into the peripheral clock domain through a two-stage synchronizer. It is then forced low when its input enable is cleared, and passed through a debounce filter. The filter for pins 3..0 and the filter for pins 7..4 are each timed by their own 3-bit code.

An edge detector runs on the debounced level. For each pin it looks for either a rising or a falling edge, and a detected edge latches a per-pin flag. The interrupt output is asserted while any flag is set whose mask bit is also set. Software reaches the block through a small byte-wide register bus. Writes take effect on the clock edge that samples `bus_wr`, and reads return data combinationally.

Register addresses on `bus_addr`:

| Address | Register |
|---|---|
| 0 | synchronized input level, read-only |
| 1 | interrupt mask |
| 2 | edge polarity |
| 3 | interrupt flags |
| 4 | debounce control |
| 5 | input enable |

Other addresses read as 0.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the registers read as follows: mask 0x00, edge polarity 0x00, flags 0x00, debounce control 0x00 and input enable 0xFF. `irq_o` is 0.
- R2: Address 0 reads the two-flop-synchronized pin levels ANDed with the input enable. Writes to address 0 have no effect.
- R3: When polarity bit i is 0, a rising edge of debounced pin i sets flag i. When polarity bit i is 1, a falling edge sets flag i. An edge of the other direction leaves the flag unchanged.
- R4: Writing 1 to flag bit i clears it, and writing 0 leaves it unchanged. If a new edge occurs on bit i in the same cycle as a clear of bit i, the flag ends up set.
- R5: `irq_o` is the OR over all pins of (flag AND mask).
- R6: In the debounce control register, bits 2..0 hold the code for pins 3..0 and bits 6..4 hold the code for pins 7..4. Bits 7 and 3 always read 0.
- R7: A nonzero code k sets a hold time of 2^(7+k) clocks (256 to 16384). The debounced level takes the new value only after the gated input has held it for that many consecutive clocks. Any return to the old level restarts the count. Pin i's flag sets 2^(7+k)+3 clocks after the pin changes.
- R8: Code 0 bypasses the filter. A pin edge sets its flag on the 4th clock edge after the pin changes.
- R9: A pin whose input enable bit is 0 reads as 0 at address 0, and toggling that pin sets no flag.
- R10: Writing a different code for a nibble restarts the hold count of every pin in that nibble from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Raw asynchronous pin levels |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
A counter or debounced bit holding a wrong value shows up as a flag that appears too early or too late. It becomes visible at flag address 3 and on `irq_o` within 2^(7+k)+3 clocks of the pin change, so the bench checks both sides of that edge to the clock. A wrong synchronizer or enable state shows up at address 0 within two clocks. A flag set or cleared in the wrong cycle is seen by reading the flags after edges, clears and their collision, and by following `irq_o` as the mask changes.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int BASE_SHIFT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pin_i,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_o
);
  localparam int CNT_W = BASE_SHIFT + 6;
  localparam logic [2:0] A_IN = 3'd0, A_MASK = 3'd1, A_EDGE = 3'd2,
                         A_FLAG = 3'd3, A_FILT = 3'd4, A_IEN = 3'd5;

  logic [7:0] mask_q, edge_q, flag_q, ien_q;
  logic [2:0] code_lo_q, code_hi_q;
  logic [7:0] sync1_q, sync2_q, filt_d_q;
  logic [7:0] gated, filt, edge_ev, clr;
  logic       restart_lo, restart_hi;

  function automatic logic [CNT_W-1:0] lim_of(input logic [2:0] c);
    lim_of = (CNT_W'(1) << (BASE_SHIFT + int'(c) - 1)) - CNT_W'(1);
  endfunction

  assign gated      = sync2_q & ien_q;
  assign restart_lo = bus_wr && bus_addr == A_FILT && bus_wdata[2:0] != code_lo_q;
  assign restart_hi = bus_wr && bus_addr == A_FILT && bus_wdata[6:4] != code_hi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      filt_d_q <= '0;
    end else begin
      sync1_q  <= pin_i;
      sync2_q  <= sync1_q;
      filt_d_q <= filt;
    end

  for (genvar i = 0; i < 8; i++) begin : g_pin
    logic [CNT_W-1:0] cnt_q;
    logic             lvl_q;
    logic [2:0]       code;
    logic             restart;
    assign code    = (i < 4) ? code_lo_q : code_hi_q;
    assign restart = (i < 4) ? restart_lo : restart_hi;
    assign filt[i] = lvl_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt_q <= '0;
        lvl_q <= 1'b0;
      end else if (code == 3'd0) begin
        cnt_q <= '0;
        lvl_q <= gated[i];
      end else if (restart || gated[i] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == lim_of(code)) begin
        cnt_q <= '0;
        lvl_q <= gated[i];
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
  end

  assign edge_ev = (edge_q & ~filt & filt_d_q) | (~edge_q & filt & ~filt_d_q);
  assign clr     = (bus_wr && bus_addr == A_FLAG) ? bus_wdata : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q    <= '0;
      edge_q    <= '0;
      flag_q    <= '0;
      ien_q     <= '1;
      code_lo_q <= '0;
      code_hi_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | edge_ev;
      if (bus_wr)
        case (bus_addr)
          A_MASK: mask_q <= bus_wdata;
          A_EDGE: edge_q <= bus_wdata;
          A_FILT: begin
            code_lo_q <= bus_wdata[2:0];
            code_hi_q <= bus_wdata[6:4];
          end
          A_IEN:  ien_q  <= bus_wdata;
          default: ;
        endcase
    end

  always_comb
    case (bus_addr)
      A_IN:    bus_rdata = gated;
      A_MASK:  bus_rdata = mask_q;
      A_EDGE:  bus_rdata = edge_q;
      A_FLAG:  bus_rdata = flag_q;
      A_FILT:  bus_rdata = {1'b0, code_hi_q, 1'b0, code_lo_q};
      A_IEN:   bus_rdata = ien_q;
      default: bus_rdata = 8'h00;
    endcase

  assign irq_o = |(flag_q & mask_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] filt,
  input logic [7:0] filt_d,
  input logic [7:0] gated,
  input logic [7:0] flag,
  input logic [7:0] edge_ev,
  input logic [2:0] code_lo,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (flag == 8'h00 && filt == 8'h00));

  p_flag_from_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag)) != 8'h00) |-> ($past(filt) != $past(filt_d)));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3) |=>
      ((flag & $past(bus_wdata) & ~$past(edge_ev)) == 8'h00));

  p_filt_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt ^ $past(filt)) & (filt ^ $past(gated))) == 8'h00);

  p_bypass_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_lo == 3'd0 && $past(code_lo) == 3'd0) |-> filt[3:0] == $past(gated[3:0]));
endmodule

bind gpio_irq_port gpio_irq_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .filt(filt), .filt_d(filt_d_q), .gated(gated),
  .flag(flag_q), .edge_ev(edge_ev), .code_lo(code_lo_q),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = 8'h00;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_o;
  int checks = 0, failures = 0;

  gpio_irq_port uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    wr(3'd4, 8'h00); wr(3'd2, 8'h00);
    pin_i = 8'h00; cyc(6);
    wr(3'd3, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd1, d); chk("R1 mask", d, 8'h00);
    rd(3'd2, d); chk("R1 edge", d, 8'h00);
    rd(3'd3, d); chk("R1 flag", d, 8'h00);
    rd(3'd4, d); chk("R1 filt", d, 8'h00);
    rd(3'd5, d); chk("R1 ien", d, 8'hFF);
    chk("R1 irq", irq_o, 1'b0);
  endtask

  task automatic t_indata();
    logic [7:0] d;
    @(negedge clk); pin_i = 8'hA5;
    cyc(1); rd(3'd0, d); chk("R2 one flop", d, 8'h00);
    cyc(1); rd(3'd0, d); chk("R2 synced", d, 8'hA5);
    wr(3'd0, 8'h3C); rd(3'd0, d); chk("R2 write ignored", d, 8'hA5);
    settle();
  endtask

  task automatic t_edges();
    logic [7:0] d;
    @(negedge clk); pin_i[1] = 1'b1;
    cyc(2); rd(3'd3, d); chk("R8 not early", d, 8'h00);
    cyc(2); rd(3'd3, d); chk("R8 rise bypass", d, 8'h02);
    pin_i[1] = 1'b0; cyc(6); rd(3'd3, d); chk("R3 fall ignored", d, 8'h02);
    wr(3'd2, 8'h04);
    pin_i[2] = 1'b1; cyc(6); rd(3'd3, d); chk("R3 rise ignored", d, 8'h02);
    pin_i[2] = 1'b0; cyc(6); rd(3'd3, d); chk("R3 falling edge", d, 8'h06);
  endtask

  task automatic t_clear_irq();
    logic [7:0] d;
    chk("R5 mask0 irq", irq_o, 1'b0);
    wr(3'd1, 8'h01); chk("R5 other mask irq", irq_o, 1'b0);
    wr(3'd1, 8'h02); chk("R5 irq set", irq_o, 1'b1);
    wr(3'd3, 8'h00); rd(3'd3, d); chk("R4 write0", d, 8'h06);
    wr(3'd3, 8'h02); rd(3'd3, d); chk("R4 clear bit1", d, 8'h04);
    chk("R5 irq dropped", irq_o, 1'b0);
    wr(3'd3, 8'h04); rd(3'd3, d); chk("R4 clear bit2", d, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    settle();
    @(negedge clk); pin_i[3] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 8'h08;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
    rd(3'd3, d); chk("R4 edge beats clear", d, 8'h08);
    wr(3'd3, 8'h08); rd(3'd3, d); chk("R4 later clear", d, 8'h00);
    settle();
  endtask

  task automatic t_filter();
    logic [7:0] d;
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R6 reserved zero", d, 8'h77);
    wr(3'd4, 8'h21); rd(3'd4, d); chk("R6 fields", d, 8'h21);
    @(negedge clk); pin_i[0] = 1'b1;
    cyc(256); rd(3'd3, d); chk("R7 lo 256 early", d, 8'h00);
    cyc(4); rd(3'd3, d); chk("R7 lo 256 set", d, 8'h01);
    @(negedge clk); pin_i[4] = 1'b1;
    cyc(512); rd(3'd3, d); chk("R7 hi 512 early", d, 8'h01);
    cyc(4); rd(3'd3, d); chk("R7 hi 512 set", d, 8'h11);
    @(negedge clk); pin_i[1] = 1'b1;
    cyc(200); pin_i[1] = 1'b0; cyc(2); pin_i[1] = 1'b1;
    cyc(200); rd(3'd3, d); chk("R7 bounce restart", d, 8'h11);
    cyc(80); rd(3'd3, d); chk("R7 after bounce", d, 8'h13);
    @(negedge clk); pin_i[2] = 1'b1;
    cyc(200); wr(3'd4, 8'h22);
    cyc(400); rd(3'd3, d); chk("R10 code change restart", d, 8'h13);
    cyc(140); rd(3'd3, d); chk("R10 new time", d, 8'h17);
    wr(3'd4, 8'h07);
    @(negedge clk); pin_i[3] = 1'b1;
    cyc(16384); rd(3'd3, d); chk("R7 16384 early", d, 8'h17);
    cyc(4); rd(3'd3, d); chk("R7 16384 set", d, 8'h1F);
    settle();
  endtask

  task automatic t_disable();
    logic [7:0] d;
    wr(3'd5, 8'h00);
    @(negedge clk); pin_i = 8'hFF;
    cyc(6);
    rd(3'd0, d); chk("R9 input zero", d, 8'h00);
    rd(3'd3, d); chk("R9 no flags", d, 8'h00);
    pin_i = 8'h00; cyc(6);
    wr(3'd5, 8'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_indata();
    t_edges();
    t_clear_irq();
    t_collide();
    t_filter();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule